// File: doc/BRIEF.md
# Seven-Channel Compare Timer with Interrupt Requests

The block is a 16-bit timer with seven compare channels. When running, the counter advances on a selected clock enable from zero up to the compare value of channel 0, then starts again at zero. Every channel compares the counter with its own compare register. When the counter takes a value equal to that register, the channel's flag sets one clock later. The flag sets whether or not the channel is enabled. The enable only decides whether the flag raises an interrupt request.

Channel 0 has a request line of its own and the highest priority. Its flag clears itself when the interrupt controller acknowledges the request. Channels 1 to 6 share one request line. Their flags stay set until software writes a zero to them. A priority index output names the lowest-numbered channel that is pending. Software reaches all state through a small word-wide register bus with a combinational read port.

Register map (word addresses): 0 = control (bit 0 run/up mode, bit 1 clock-enable select, bit 2 clear); 1 = counter, read only; 2+i = channel i control (bit 0 flag, bit 1 enable); 9+i = channel i compare value.

Top module: `tmr_compare_top`

## Requirements
- R1: After reset the counter, every compare value, every flag, every enable and every control bit read as zero. Both request lines are low and the priority index reads 7.
- R2: With run set (control bit 0 = 1), each selected enable pulse advances the counter by one. When the counter equals the channel 0 compare value, the pulse loads zero instead.
- R3: Control bit 1 selects the counting enable: 0 selects `tick_a` and 1 selects `tick_b`. Pulses on the unselected input have no effect on the counter.
- R4: Writing 1 to control bit 2 zeroes the counter on the next clock edge. The bit reads 1 for exactly that one cycle and then reads 0.
- R5: A channel's flag (bit 0 of its control word) sets one clock after the counter is loaded with a value equal to that channel's compare value. This happens whatever the state of the enable.
- R6: Without any configuration after reset, channels 1 to 6 (compare value 0) set their flags once the running counter passes through zero.
- R7: A pulse on `irq0_ack` clears the channel 0 flag unless a match sets it in the same cycle.
- R8: `irq0_ack` does not clear the flags of channels 1 to 6. They clear only when software writes 0 to flag bit 0. A match in the same cycle wins over the write.
- R9: Writing 1 to channel 0 flag bit 0 sets the flag, and with the channel enabled it raises `irq0`.
- R10: `irq0` is high exactly when the channel 0 flag and enable are both set. `irq_grp` is high exactly when some channel 1..6 has both its flag and enable set.
- R11: `irq_id` gives the lowest channel index with flag and enable both set, so channel 0 wins over all others. It reads 7 when no channel qualifies.
- R12: With run clear (control bit 0 = 0) and no clear pending, the counter holds its value and no new matches occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_a | input | 1 | Counting enable source A |
| tick_b | input | 1 | Counting enable source B |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq0_ack | input | 1 | Acknowledge of the channel 0 request |
| irq0 | output | 1 | Channel 0 interrupt request |
| irq_grp | output | 1 | Shared request for channels 1..6 |
| irq_id | output | 3 | Highest-priority pending channel, 7 if none |

## Verification
Directed sequences test each stimulus alone. One runs the timer untouched after reset to show the unconfigured channels flagging. Others alternate the two enable sources to separate the select states, and issue acknowledge and zero-writes to tell the self-clearing flag from the sticky ones. A short wrap period followed by a clear pins down the exact counting sequence. The bench then drives a long random mix of register writes, small compare values, random enable pulses and acknowledges. Matches, acknowledges and writes then collide in the same cycle, and a cycle model checks which one takes precedence.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int TMR_CNT_W    = 16;
    localparam int TMR_N_CH     = 7;
    // control word bit positions
    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_SEL_BIT = 1;
    localparam int CTRL_CLR_BIT = 2;
    // channel control word bit positions
    localparam int CHF_FLAG_BIT = 0;
    localparam int CHF_EN_BIT   = 1;

    typedef struct packed {
        logic run;
        logic sel;
        logic clr;
    } ctrl_t;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] top_val,
    output logic [CNT_W-1:0] cnt_o,
    output logic             loaded_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             loaded;
    } cstate_t;

    cstate_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.loaded = 1'b0;
        if (clr) begin
            st_d.cnt    = '0;
            st_d.loaded = 1'b1;
        end else if (run && tick) begin
            st_d.cnt    = (st_q.cnt == top_val) ? '0 : st_q.cnt + 1'b1;
            st_d.loaded = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o    = st_q.cnt;
    assign loaded_o = st_q.loaded;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
    parameter int CNT_W   = 16,
    parameter bit PRIMARY = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             loaded,
    input  logic             wr_ctl,
    input  logic             wr_cmp,
    input  logic [CNT_W-1:0] wdata,
    input  logic             ack,
    output logic             hit_o,
    output logic             flag_o,
    output logic             en_o,
    output logic [CNT_W-1:0] cmp_o
);
    import tmr_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             flag;
        logic             en;
    } chstate_t;

    chstate_t st_d, st_q;
    logic     hit;
    logic     ack_clr;

    generate
        if (PRIMARY) begin : g_self_clear
            assign ack_clr = ack;
        end else begin : g_sticky
            assign ack_clr = ack & 1'b0;
        end
    endgenerate

    assign hit = loaded && (cnt == st_q.cmp);

    always_comb begin
        st_d = st_q;
        if (wr_cmp) st_d.cmp = wdata;
        if (wr_ctl) st_d.en  = wdata[CHF_EN_BIT];
        if (hit)
            st_d.flag = 1'b1;
        else if (wr_ctl)
            st_d.flag = wdata[CHF_FLAG_BIT];
        else if (ack_clr)
            st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit_o  = hit;
    assign flag_o = st_q.flag;
    assign en_o   = st_q.en;
    assign cmp_o  = st_q.cmp;
endmodule

// File: rtl/tmr_prio.sv
module tmr_prio #(
    parameter int N_CH = 7,
    localparam int IDW = $clog2(N_CH + 1)
) (
    input  logic [N_CH-1:0] req,
    output logic [IDW-1:0]  id
);
    always_comb begin
        id = IDW'(N_CH);
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (req[i]) id = IDW'(i);
        end
    end
endmodule

// File: rtl/tmr_compare_top.sv
module tmr_compare_top #(
    parameter int CNT_W = tmr_pkg::TMR_CNT_W,
    parameter int N_CH  = tmr_pkg::TMR_N_CH,
    localparam int CTL_BASE = 2,
    localparam int CMP_BASE = CTL_BASE + N_CH,
    localparam int AW       = $clog2(CMP_BASE + N_CH),
    localparam int IDW      = $clog2(N_CH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_a,
    input  logic             tick_b,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             irq0_ack,
    output logic             irq0,
    output logic             irq_grp,
    output logic [IDW-1:0]   irq_id
);
    import tmr_pkg::*;

    ctrl_t ctrl_d, ctrl_q;

    logic             run;
    logic             clr;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             loaded;
    logic [CNT_W-1:0] cmp0;
    logic [N_CH-1:0]  hit;
    logic [N_CH-1:0]  flag;
    logic [N_CH-1:0]  en;
    logic [N_CH-1:0]  wr_ctl;
    logic [N_CH-1:0]  wr_cmp;
    logic [N_CH-1:0]  pend;
    logic [CNT_W-1:0] cmp_arr [N_CH];

    // control register: run/select hold, clear lasts one cycle
    always_comb begin
        ctrl_d     = ctrl_q;
        ctrl_d.clr = 1'b0;
        if (bus_we && bus_addr == AW'(0)) begin
            ctrl_d.run = bus_wdata[CTRL_RUN_BIT];
            ctrl_d.sel = bus_wdata[CTRL_SEL_BIT];
            ctrl_d.clr = bus_wdata[CTRL_CLR_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign run  = ctrl_q.run;
    assign clr  = ctrl_q.clr;
    assign tick = ctrl_q.sel ? tick_b : tick_a;

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (tick),
        .clr      (clr),
        .top_val  (cmp0),
        .cnt_o    (cnt),
        .loaded_o (loaded)
    );

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_ch
            assign wr_ctl[g] = bus_we && (bus_addr == AW'(CTL_BASE + g));
            assign wr_cmp[g] = bus_we && (bus_addr == AW'(CMP_BASE + g));

            tmr_chan #(.CNT_W(CNT_W), .PRIMARY(g == 0)) u_ch (
                .clk    (clk),
                .rst_n  (rst_n),
                .cnt    (cnt),
                .loaded (loaded),
                .wr_ctl (wr_ctl[g]),
                .wr_cmp (wr_cmp[g]),
                .wdata  (bus_wdata),
                .ack    (irq0_ack),
                .hit_o  (hit[g]),
                .flag_o (flag[g]),
                .en_o   (en[g]),
                .cmp_o  (cmp_arr[g])
            );
        end
    endgenerate

    assign cmp0    = cmp_arr[0];
    assign pend    = flag & en;
    assign irq0    = pend[0];
    assign irq_grp = |pend[N_CH-1:1];

    tmr_prio #(.N_CH(N_CH)) u_prio (
        .req (pend),
        .id  (irq_id)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(0)) begin
            bus_rdata[CTRL_RUN_BIT] = ctrl_q.run;
            bus_rdata[CTRL_SEL_BIT] = ctrl_q.sel;
            bus_rdata[CTRL_CLR_BIT] = ctrl_q.clr;
        end else if (bus_addr == AW'(1)) begin
            bus_rdata = cnt;
        end
        for (int i = 0; i < N_CH; i++) begin
            if (bus_addr == AW'(CTL_BASE + i)) begin
                bus_rdata[CHF_FLAG_BIT] = flag[i];
                bus_rdata[CHF_EN_BIT]   = en[i];
            end
            if (bus_addr == AW'(CMP_BASE + i)) bus_rdata = cmp_arr[i];
        end
    end
endmodule

// File: rtl/tmr_compare_chk.sv
module tmr_compare_chk #(
    parameter int CNT_W = 16,
    parameter int N_CH  = 7,
    localparam int CTL_BASE = 2,
    localparam int AW       = $clog2(CTL_BASE + 2 * N_CH),
    localparam int IDW      = $clog2(N_CH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [AW-1:0]    bus_addr,
    input logic [CNT_W-1:0] bus_wdata,
    input logic             irq0_ack,
    input logic             irq0,
    input logic             irq_grp,
    input logic [IDW-1:0]   irq_id,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp0,
    input logic             run,
    input logic             clr,
    input logic             tick,
    input logic [N_CH-1:0]  hit,
    input logic [N_CH-1:0]  flag
);
    logic clr_rewrite;
    assign clr_rewrite = bus_we && bus_addr == AW'(0) && bus_wdata[2];

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run && !clr && tick && cnt != cmp0 |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R2
    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        run && !clr && tick && cnt == cmp0 |=> cnt == '0); // R2
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0); // R4
    AST_CLR_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !clr_rewrite |=> !clr); // R4
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !clr |=> $stable(cnt)); // R12
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        irq0_ack && !hit[0] && !(bus_we && bus_addr == AW'(CTL_BASE)) |=> !flag[0]); // R7
    AST_PRIO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq0 |-> irq_id == '0); // R11
    AST_IDLE_ID: assert property (@(posedge clk) disable iff (!rst_n)
        !irq0 && !irq_grp |-> irq_id == IDW'(N_CH)); // R11

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_hit
            AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                hit[g] |=> flag[g]); // R5
        end
        for (genvar g = 1; g < N_CH; g++) begin : g_sticky
            AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                flag[g] && !(bus_we && bus_addr == AW'(CTL_BASE + g)) |=> flag[g]); // R8
        end
    endgenerate
endmodule

bind tmr_compare_top tmr_compare_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq0_ack  (irq0_ack),
    .irq0      (irq0),
    .irq_grp   (irq_grp),
    .irq_id    (irq_id),
    .cnt       (cnt),
    .cmp0      (cmp0),
    .run       (run),
    .clr       (clr),
    .tick      (tick),
    .hit       (hit),
    .flag      (flag)
);

// File: tb/tmr_compare_top_tb.sv
`timescale 1ns/1ps
module tmr_compare_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_a = 1'b1;
    logic        tick_b = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq0_ack = 1'b0;
    logic        irq0;
    logic        irq_grp;
    logic [2:0]  irq_id;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_compare_top u_dut (
        .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq0_ack(irq0_ack), .irq0(irq0),
        .irq_grp(irq_grp), .irq_id(irq_id)
    );

    // ---------------- cycle model built from the requirements ----------------
    logic [15:0] m_cnt;
    logic        m_new, m_run, m_sel, m_clr;
    logic [6:0]  m_flag, m_en;
    logic [15:0] m_cmp [7];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = '0; m_new = 0; m_run = 0; m_sel = 0; m_clr = 0;
            m_flag = '0; m_en = '0;
            for (int i = 0; i < 7; i++) m_cmp[i] = '0;
        end else begin
            logic       tk;
            logic [6:0] h;
            logic [15:0] ncnt;
            logic        nnew;
            tk = m_sel ? tick_b : tick_a;
            for (int i = 0; i < 7; i++) h[i] = m_new && (m_cnt == m_cmp[i]);
            if (m_clr) begin ncnt = '0; nnew = 1; end
            else if (m_run && tk) begin
                ncnt = (m_cnt == m_cmp[0]) ? 16'd0 : m_cnt + 16'd1; nnew = 1;
            end else begin ncnt = m_cnt; nnew = 0; end
            m_clr = bus_we && bus_addr == 4'd0 && bus_wdata[2];
            if (bus_we && bus_addr == 4'd0) begin
                m_run = bus_wdata[0]; m_sel = bus_wdata[1];
            end
            for (int i = 0; i < 7; i++) begin
                logic wc;
                wc = bus_we && bus_addr == 4'(2 + i);
                if (h[i]) m_flag[i] = 1'b1;
                else if (wc) m_flag[i] = bus_wdata[0];
                else if (i == 0 && irq0_ack) m_flag[i] = 1'b0;
                if (wc) m_en[i] = bus_wdata[1];
                if (bus_we && bus_addr == 4'(9 + i)) m_cmp[i] = bus_wdata;
            end
            m_cnt = ncnt; m_new = nnew;
        end
    end

    function automatic logic [15:0] exp_read(input logic [3:0] a);
        if (a == 4'd0) return {13'd0, m_clr, m_sel, m_run};
        if (a == 4'd1) return m_cnt;
        if (a >= 4'd2 && a <= 4'd8) return {14'd0, m_en[a-2], m_flag[a-2]};
        return m_cmp[a-9];
    endfunction

    function automatic logic [2:0] exp_id();
        logic [6:0] p;
        p = m_flag & m_en;
        for (int i = 0; i < 7; i++) if (p[i]) return 3'(i);
        return 3'd7;
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
        end
    endtask

    task automatic auto_check();
        string t;
        t = (bus_addr == 0) ? "R4 ctrl" : (bus_addr == 1) ? "R2 count" : "R5 channel reg";
        chk(t, bus_rdata, exp_read(bus_addr));
        chk("R10 irq0", irq0, m_flag[0] & m_en[0]);
        chk("R10 irq_grp", irq_grp, |(m_flag[6:1] & m_en[6:1]));
        chk("R11 irq_id", irq_id, exp_id());
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        auto_check();
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        step();
        bus_we = 0;
    endtask

    task automatic rd(input string tag, input logic [3:0] a, input logic [15:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [15:0] v1;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        auto_check();

        // R1 reset state
        rd("R1 ctrl", 0, 0);
        rd("R1 count", 1, 0);
        for (int i = 0; i < 7; i++) rd("R1 chan ctl", 4'(2 + i), 0);
        rd("R1 cmp0", 9, 0);
        chk("R1 irq0", irq0, 0);
        chk("R1 irq_grp", irq_grp, 0);
        chk("R1 irq_id", irq_id, 7);

        // R6 unconfigured channels flag once the counter wraps
        wr(9, 3);
        wr(0, 1);
        repeat (10) step();
        for (int i = 1; i < 7; i++) rd("R6 idle channel flag", 4'(2 + i), 1);
        rd("R5 ch0 flag without enable", 2, 1);
        chk("R10 irq0 disabled", irq0, 0);
        chk("R10 irq_grp disabled", irq_grp, 0);

        // R12 stop mode holds the count
        wr(0, 0);
        bus_addr = 1; #1; v1 = bus_rdata;
        repeat (5) step();
        rd("R12 count held", 1, v1);

        // R9 software set of channel 0 flag
        wr(2, 3);
        chk("R9 irq0 raised", irq0, 1);
        chk("R11 ch0 wins", irq_id, 0);

        // R7 acknowledge clears channel 0, R8 not channel 1
        irq0_ack = 1; step(); irq0_ack = 0;
        chk("R7 irq0 after ack", irq0, 0);
        rd("R7 ch0 flag after ack", 2, 2);
        rd("R8 ch1 flag survives ack", 3, 1);
        wr(3, 0);
        rd("R8 ch1 cleared by write", 3, 0);

        // R11 priority
        wr(4, 3);
        chk("R10 irq_grp ch2", irq_grp, 1);
        chk("R11 id ch2", irq_id, 2);
        wr(2, 3);
        chk("R11 id ch0 over ch2", irq_id, 0);

        // R4 clear
        wr(0, 4);
        rd("R4 clear bit visible", 0, 4);
        step();
        rd("R4 clear bit gone", 0, 0);
        rd("R4 count zeroed", 1, 0);

        // R3 clock select
        wr(9, 100);
        wr(0, 3);
        repeat (4) step();
        rd("R3 tick_a ignored", 1, 0);
        tick_b = 1; step(); tick_b = 0;
        rd("R3 tick_b counts", 1, 1);
        wr(0, 1);
        repeat (3) step();
        rd("R3 tick_a counts", 1, 4);

        // R2 exact wrap sequence with compare 2
        wr(9, 2);
        wr(0, 5);
        step(); rd("R2 seq after clear", 1, 0);
        step(); rd("R2 seq 1", 1, 1);
        step(); rd("R2 seq 2", 1, 2);
        step(); rd("R2 seq wrap", 1, 0);

        // random mix against the cycle model
        for (int c = 0; c < 4000; c++) begin
            logic [3:0] a;
            a = 4'($urandom % 16);
            bus_we = ($urandom % 4) == 0;
            bus_addr = a;
            if (a == 0)
                bus_wdata = {13'd0, ($urandom % 16) == 0, 1'($urandom), ($urandom % 8) != 0};
            else if (a >= 9)
                bus_wdata = 16'($urandom % 24);
            else
                bus_wdata = 16'($urandom);
            irq0_ack = ($urandom % 6) == 0;
            tick_a = 1'($urandom);
            tick_b = ($urandom % 3) == 0;
            step();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule